// File: doc/BRIEF.md
# Prioritized Serial-Port Interrupt Identifier

This block sits beside a serial port and reduces three interrupt conditions to a single read-only identification byte and one interrupt output. The conditions are a receiver line-status error, received data being ready, and the transmit holding register becoming empty. Each condition can be enabled separately. Only enabled conditions compete, and the highest-priority pending one is reported. The line-status and data-ready conditions arrive as levels owned by the surrounding port. The holding-register-empty condition arrives as a one-cycle event, and this block latches it.

A host reads the identification byte through a strobe interface. `rd_stb` stays high for the whole access, and `rd_addr` selects offset 2. A small state machine takes a snapshot of the identification when a selected access begins. It holds both the snapshot and the interrupt output until the access ends, so conditions that arrive mid-read cannot change what the host sees. When an access ends that reported the transmitter-empty condition, the latched condition is cleared. It is raised again only by the next empty event.

State machine states and transitions:
- `FZ_IDLE`: live tracking. It moves to `FZ_HOLD` when a selected access starts.
- `FZ_HOLD`: the snapshot and interrupt output are frozen. It stays in `FZ_HOLD` while the access remains selected. It moves to `FZ_RELEASE` when the access ends, and at that step it issues the transmitter-empty clear if that condition was the one reported.
- `FZ_RELEASE`: the interrupt output is refreshed. It moves to `FZ_HOLD` if a new selected access starts, and otherwise to `FZ_IDLE`.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `irq` is 0, and a read at offset 2 returns 0x01, meaning nothing is pending.
- R2: Priority is fixed, from highest to lowest: line status, then data ready, then transmitter empty.
- R3: Bit 0 of the identification byte is 0 when an enabled condition is pending and 1 otherwise. Bits 2:1 hold 2'b11 for line status, 2'b10 for data ready, 2'b01 for transmitter empty, and 2'b00 when nothing is pending. The resulting byte values are 0x06, 0x04, 0x02 and 0x01.
- R4: Bits 7:3 of the identification byte always read as 0.
- R5: `src_en[2]` enables line status, `src_en[1]` enables data ready, and `src_en[0]` enables transmitter empty. A source with a cleared enable bit neither appears in the byte nor drives `irq`.
- R6: During a selected access, `rd_data` keeps the value captured in the first cycle of that access. This holds even if new conditions arrive.
- R7: Only offset 2 selects the register. An access at any other offset returns 0x00, freezes nothing and clears nothing.
- R8: The latched transmitter-empty condition is cleared when an access that reported it ends. An access that reported a higher-priority source leaves it latched.
- R9: If a transmitter-empty event arrives in the same cycle as the clear, the event wins and the condition stays pending.
- R10: `irq` follows "any enabled condition pending" one cycle later. It is held during a selected access and is refreshed on the second clock edge after the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rls_cond | input | 1 | Receiver line-status condition level |
| rdr_cond | input | 1 | Received-data-ready condition level |
| thre_set | input | 1 | One-cycle pulse: holding register became empty |
| src_en | input | 3 | Per-source enables (line status, data ready, transmitter empty) |
| rd_stb | input | 1 | Host read active, high for the whole access |
| rd_addr | input | 3 | Register offset of the access |
| rd_data | output | 8 | Identification byte when offset 2 is selected, else 0 |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same clock edge. One is the clear of the latched transmitter-empty condition as a reporting access ends. The other is a fresh empty event that must re-arm that condition. The bench lowers the read strobe and pulses `thre_set` in the same cycle, then reads again. It judges the design correct only if the second read still reports transmitter empty, and contrasts this with the same sequence without the pulse, which must read as nothing pending. A second overlap, new conditions arriving during a frozen read, is checked by requiring both the byte and `irq` to stay unchanged until the release.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    // Number of interrupt sources handled by the identifier
    localparam int NUM_SRC = 3;

    // Source index inside request vectors (priority grows with index)
    localparam int IDX_THRE = 0;
    localparam int IDX_RDR  = 1;
    localparam int IDX_RLS  = 2;

    // Freeze state machine
    typedef enum logic [1:0] {
        FZ_IDLE    = 2'd0,
        FZ_HOLD    = 2'd1,
        FZ_RELEASE = 2'd2
    } fz_state_e;

    // Source identification codes reported in bits 2:1
    typedef enum logic [1:0] {
        ID_NONE = 2'b00,
        ID_THRE = 2'b01,
        ID_RDR  = 2'b10,
        ID_RLS  = 2'b11
    } src_id_e;

    typedef struct packed {
        logic    pending;
        src_id_e id;
    } irq_ident_t;

    localparam irq_ident_t IDENT_IDLE = '{pending: 1'b0, id: ID_NONE};

endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch
    import uart_irq_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_rls,
    input  logic             lvl_rdr,
    input  logic             thre_set,
    input  logic             thre_clr,
    input  logic [N_SRC-1:0] src_en,
    output logic [N_SRC-1:0] req_masked
);

    logic             thre_q;
    logic [N_SRC-1:0] raw_req;

    // Transmitter-empty condition: a new event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thre_q <= 1'b0;
        end else if (thre_set) begin
            thre_q <= 1'b1;
        end else if (thre_clr) begin
            thre_q <= 1'b0;
        end
    end

    always_comb begin
        raw_req           = '0;
        raw_req[IDX_THRE] = thre_q;
        raw_req[IDX_RDR]  = lvl_rdr;
        raw_req[IDX_RLS]  = lvl_rls;
    end

    // Per-source enable gating
    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_mask
            assign req_masked[g] = raw_req[g] & src_en[g];
        end
    endgenerate

    // R8: the latched condition only drops through the clear strobe
    assert_thre_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(thre_q) |-> $past(thre_clr))
        else $error("latched condition dropped without clear");

    // R9: an event always leaves the condition latched
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        thre_set |=> thre_q)
        else $error("event lost against clear");

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import uart_irq_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic [N_SRC-1:0] req,
    output irq_ident_t       ident
);

    localparam int IDW = $bits(src_id_e);

    // Walk from lowest to highest priority so the last hit wins
    always_comb begin
        ident = IDENT_IDLE;
        for (int i = 0; i < N_SRC; i++) begin
            if (req[i]) begin
                ident.pending = 1'b1;
                ident.id      = src_id_e'(IDW'(i + 1));
            end
        end
    end

    // R2: priority ordering
    always_comb begin
        if (req[IDX_RLS]) begin
            assert_rls_top_R2: assert (ident.id == ID_RLS)
                else $error("line status not on top");
        end
        if (req[IDX_RDR] && !req[IDX_RLS]) begin
            assert_rdr_mid_R2: assert (ident.id == ID_RDR)
                else $error("data ready misordered");
        end
    end

    // R3: pending flag matches a nonzero code
    always_comb begin
        assert_pend_code_R3: assert (ident.pending == (ident.id != ID_NONE))
            else $error("pending flag and code disagree");
    end

endmodule

// File: rtl/irq_freeze_fsm.sv
module irq_freeze_fsm
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 8,
    parameter int ID_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  irq_ident_t        live,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              thre_clr
);

    localparam int ID_BITS = $bits(irq_ident_t);
    localparam int PAD_W   = DATA_W - ID_BITS;

    fz_state_e  state_q, state_d;
    irq_ident_t snap_q;
    irq_ident_t shown;
    logic       irq_q;
    logic       sel;

    assign sel = rd_stb && (rd_addr == ADDR_W'(ID_ADDR));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FZ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FZ_IDLE:    if (sel)  state_d = FZ_HOLD;
            FZ_HOLD:    if (!sel) state_d = FZ_RELEASE;
            FZ_RELEASE: state_d = sel ? FZ_HOLD : FZ_IDLE;
            default:    state_d = FZ_IDLE;
        endcase
    end

    // Registered outputs: snapshot and interrupt line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= IDENT_IDLE;
            irq_q  <= 1'b0;
        end else begin
            unique case (state_q)
                FZ_IDLE, FZ_RELEASE: begin
                    irq_q <= live.pending;
                    if (sel) snap_q <= live;
                end
                FZ_HOLD: begin
                    snap_q <= snap_q;
                    irq_q  <= irq_q;
                end
                default: begin
                    snap_q <= IDENT_IDLE;
                    irq_q  <= 1'b0;
                end
            endcase
        end
    end

    // Combinational outputs
    always_comb begin
        shown    = (state_q == FZ_HOLD) ? snap_q : live;
        thre_clr = (state_q == FZ_HOLD) && !sel && (snap_q.id == ID_THRE);
        rd_data  = '0;
        if (sel) begin
            rd_data = {{PAD_W{1'b0}}, shown.id, ~shown.pending};
        end
    end

    assign irq = irq_q;

    // R4: upper bits of the byte stay zero
    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:ID_BITS] == '0)
        else $error("upper identification bits set");

    // R6: snapshot held across a frozen access
    assert_snap_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FZ_HOLD && $past(state_q) == FZ_HOLD) |-> $stable(snap_q))
        else $error("snapshot moved while frozen");

    // R10: interrupt line held across a frozen access
    assert_irq_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FZ_HOLD && $past(state_q) == FZ_HOLD) |-> $stable(irq))
        else $error("interrupt line moved while frozen");

    // R7: an unselected offset never starts a freeze
    assert_other_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FZ_IDLE && !sel) |=> state_q == FZ_IDLE)
        else $error("freeze entered without selection");

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 8,
    parameter int ID_ADDR = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rls_cond,
    input  logic               rdr_cond,
    input  logic               thre_set,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               rd_stb,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq
);

    logic [NUM_SRC-1:0] req_masked;
    irq_ident_t         live_ident;
    logic               thre_clr;

    irq_src_latch #(.N_SRC(NUM_SRC)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_rls    (rls_cond),
        .lvl_rdr    (rdr_cond),
        .thre_set   (thre_set),
        .thre_clr   (thre_clr),
        .src_en     (src_en),
        .req_masked (req_masked)
    );

    irq_prio_enc #(.N_SRC(NUM_SRC)) u_enc (
        .req   (req_masked),
        .ident (live_ident)
    );

    irq_freeze_fsm #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .ID_ADDR (ID_ADDR)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .rd_addr  (rd_addr),
        .live     (live_ident),
        .rd_data  (rd_data),
        .irq      (irq),
        .thre_clr (thre_clr)
    );

    // R5: a fully disabled block never raises the interrupt line
    assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en == '0 && $past(src_en) == '0 && $past(rst_n)) |-> !irq)
        else $error("interrupt with all sources disabled");

endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rls_cond = 1'b0;
    logic       rdr_cond = 1'b0;
    logic       thre_set = 1'b0;
    logic [2:0] src_en = 3'b000;
    logic       rd_stb = 1'b0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    uart_irq_ident u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .rls_cond (rls_cond),
        .rdr_cond (rdr_cond),
        .thre_set (thre_set),
        .src_en   (src_en),
        .rd_stb   (rd_stb),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .irq      (irq)
    );

    // Vector: {rls, rdr, thre_event, src_en[2:0], expected byte}
    localparam int NV = 10;
    localparam logic [13:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b1, 3'b111, 8'h06},
        {1'b0, 1'b1, 1'b1, 3'b111, 8'h04},
        {1'b0, 1'b0, 1'b1, 3'b111, 8'h02},
        {1'b0, 1'b0, 1'b0, 3'b111, 8'h01},
        {1'b1, 1'b1, 1'b1, 3'b011, 8'h04},
        {1'b1, 1'b1, 1'b1, 3'b001, 8'h02},
        {1'b1, 1'b1, 1'b1, 3'b000, 8'h01},
        {1'b1, 1'b0, 1'b1, 3'b101, 8'h06},
        {1'b0, 1'b1, 1'b0, 3'b010, 8'h04},
        {1'b1, 1'b0, 1'b0, 3'b011, 8'h01}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic pulse_thre();
        @(negedge clk) thre_set = 1'b1;
        @(negedge clk) thre_set = 1'b0;
    endtask

    // Begin a read at offset a; returns with the bench at a negedge inside the access
    task automatic rd_begin(input logic [2:0] a);
        @(negedge clk);
        rd_addr = a;
        rd_stb  = 1'b1;
        @(negedge clk);
    endtask

    // End the access; returns at the negedge after the interrupt line refresh
    task automatic rd_end();
        rd_stb = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_full(output logic [7:0] v);
        rd_begin(3'd2);
        v = rd_data;
        rd_end();
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq", {7'd0, irq}, 8'h00);
        rd_full(v);
        check("R1 read", v, 8'h01);

        // R2 R3 R5 table walk
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            rls_cond = VEC[k][13];
            rdr_cond = VEC[k][12];
            src_en   = VEC[k][10:8];
            if (VEC[k][11]) pulse_thre();
            @(negedge clk);
            @(negedge clk);
            check($sformatf("R10 irq vec%0d", k), {7'd0, irq},
                  {7'd0, VEC[k][7:0] != 8'h01});
            rd_begin(3'd2);
            check($sformatf("R2/R3/R5 vec%0d", k), rd_data, VEC[k][7:0]);
            check($sformatf("R4 vec%0d", k), rd_data & 8'hF8, 8'h00);
            rd_end();
            // drain any latched transmitter-empty condition
            rls_cond = 1'b0;
            rdr_cond = 1'b0;
            src_en   = 3'b111;
            rd_full(v);
        end

        // R6 R10: freeze while new conditions arrive
        src_en = 3'b111;
        @(negedge clk);
        rd_begin(3'd2);
        rdr_cond = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R6 frozen byte", rd_data, 8'h01);
        check("R10 irq held", {7'd0, irq}, 8'h00);
        rls_cond = 1'b1;
        @(negedge clk);
        check("R6 frozen after second arrival", rd_data, 8'h01);
        rd_end();
        check("R10 irq after release", {7'd0, irq}, 8'h01);
        rd_full(v);
        check("R2 line status after release", v, 8'h06);
        rls_cond = 1'b0;
        rdr_cond = 1'b0;

        // R8: higher source reported leaves transmitter empty latched
        rdr_cond = 1'b1;
        pulse_thre();
        rd_full(v);
        check("R8 data ready reported", v, 8'h04);
        rdr_cond = 1'b0;
        rd_full(v);
        check("R8 still latched", v, 8'h02);
        rd_full(v);
        check("R8 cleared after report", v, 8'h01);
        check("R10 irq low after clear", {7'd0, irq}, 8'h00);

        // R9: event in same cycle as clear
        pulse_thre();
        rd_begin(3'd2);
        check("R9 first read", rd_data, 8'h02);
        rd_stb   = 1'b0;
        thre_set = 1'b1;
        @(posedge clk);
        @(negedge clk);
        thre_set = 1'b0;
        @(negedge clk);
        rd_full(v);
        check("R9 set wins over clear", v, 8'h02);
        rd_full(v);
        check("R9 then cleared", v, 8'h01);

        // R7: other offset reads zero and clears nothing
        pulse_thre();
        rd_begin(3'd1);
        check("R7 other offset", rd_data, 8'h00);
        rd_end();
        rd_full(v);
        check("R7 nothing cleared", v, 8'h02);

        // R5: disabled source does not drive irq
        src_en = 3'b000;
        pulse_thre();
        @(negedge clk);
        @(negedge clk);
        check("R5 irq masked", {7'd0, irq}, 8'h00);
        src_en = 3'b111;
        rd_full(v);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        done = 1'b1;
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule